// File: doc/BRIEF.md
# Secure exception routing controller

This block sits beside a processor's exception entry logic and decides, for every cycle in which an exception is pending, which mode takes it and which vector base the entry uses. It handles three exception sources: external abort, fast interrupt (FIQ) and normal interrupt (IRQ). Three routing inputs can redirect each source to a secure monitor mode. A monitor entry selects the monitor vector base. When it happens outside debug state, it also forces the held security-state bit to secure.

The block also holds the three exception mask bits: abort, FIQ and IRQ. It filters software writes to them. Two lock inputs stop code running in non-secure state from setting the abort mask or the FIQ mask. Clearing a mask is always allowed, and so is any write made in secure state. At most one exception is granted per cycle. The grant is reported one clock after the request is seen, together with the target mode and the base select.

Top module: `exc_route_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), ns_state=0 (secure), mask_a=mask_f=mask_i=0 and take_vld=0.
- R2: Requests are sampled at a clock edge and the grant appears on take_vld/take_mode/take_mon_base after that edge. At most one is granted, in the fixed order external abort, then FIQ, then IRQ.
- R3: A request is not granted while its own mask bit is 1 (req_abt with mask_a, req_fiq with mask_f, req_irq with mask_i). The next unmasked request in order is granted instead.
- R4: With its routing input at 0, a granted exception goes to its default mode: take_mode encodes 0=abort, 1=FIQ, 2=IRQ. take_mon_base is then 0 (normal base).
- R5: With its routing input at 1 (route_abt_mon, route_fiq_mon, route_irq_mon), a granted exception goes to monitor mode (take_mode=3) with take_mon_base=1.
- R6: A monitor entry granted while dbg_mode=0 sets ns_state to 0 at that same edge. This overrides an ns_wr in the same cycle.
- R7: A monitor entry granted while dbg_mode=1 leaves ns_state unchanged.
- R8: With lock_abt_mask=1 and ns_state=1, a mask write with msk_wr_a=1 leaves mask_a unchanged.
- R9: With lock_fiq_mask=1 and ns_state=1, a mask write with msk_wr_f=1 leaves mask_f unchanged.
- R10: Every other mask write takes effect at the next edge: writes in secure state, writes of 0, writes while unlocked, and all writes to mask_i.
- R11: When a mask write and a grant fall in the same cycle, the grant uses the mask values held before the write. The write is judged against the security state held before any monitor entry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_abt | input | 1 | External abort pending |
| req_fiq | input | 1 | Fast interrupt pending |
| req_irq | input | 1 | Normal interrupt pending |
| dbg_mode | input | 1 | Core is in debug state |
| route_abt_mon | input | 1 | Send external aborts to monitor mode |
| route_fiq_mon | input | 1 | Send FIQs to monitor mode |
| route_irq_mon | input | 1 | Send IRQs to monitor mode |
| lock_abt_mask | input | 1 | Forbid non-secure setting of the abort mask |
| lock_fiq_mask | input | 1 | Forbid non-secure setting of the FIQ mask |
| ns_wr | input | 1 | Write strobe for the security-state bit |
| ns_wr_val | input | 1 | Value for the security-state bit (1 = non-secure) |
| msk_wr | input | 1 | Write strobe for all three mask bits |
| msk_wr_a | input | 1 | New abort mask value |
| msk_wr_f | input | 1 | New FIQ mask value |
| msk_wr_i | input | 1 | New IRQ mask value |
| ns_state | output | 1 | Held security-state bit (1 = non-secure) |
| mask_a | output | 1 | Abort mask |
| mask_f | output | 1 | FIQ mask |
| mask_i | output | 1 | IRQ mask |
| take_vld | output | 1 | An exception was granted at the last edge |
| take_mode | output | 2 | Target mode: 0 abort, 1 FIQ, 2 IRQ, 3 monitor |
| take_mon_base | output | 1 | 1 = monitor vector base, 0 = normal base |

## Verification
A monitor entry and a software update of the same state can fall in one cycle. This happens in two ways: an exception with a mask write, and an exception with a security-state write. The bench provokes the first by raising a routed external abort in the same cycle as a non-secure, locked write that sets the abort mask. It judges the result by checking three things together: the grant goes to monitor, ns_state clears, and mask_a stays 0, because the write counted as non-secure. The second case combines a monitor entry with ns_wr=1. The entry must win, so ns_state must read 0 afterwards.

// File: rtl/exc_route_pkg.sv
// Package: shared types and source indices for the exception routing controller.
// Assumes: three exception sources, indexed in their fixed service order.
package exc_route_pkg;
    localparam int NSRC    = 3;
    localparam int IDX_ABT = 0;
    localparam int IDX_FIQ = 1;
    localparam int IDX_IRQ = 2;

    typedef enum logic [1:0] {
        MD_ABT = 2'd0,
        MD_FIQ = 2'd1,
        MD_IRQ = 2'd2,
        MD_MON = 2'd3
    } exc_mode_e;
endpackage

// File: rtl/exc_arbiter.sv
// Module: fixed-order arbiter, lowest index wins, masked sources are skipped.
// Assumes: req and mask are aligned by source index; output is combinational.
module exc_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] mask,
    output logic         vld,
    output logic [N-1:0] gnt,
    output logic [$clog2(N)-1:0] idx
);
    logic [N-1:0] live;
    assign live = req & ~mask;

    // Purpose: pick the first live source in index order.
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (live[k]) begin
                gnt = '0;
                gnt[k] = 1'b1;
                idx = k[$clog2(N)-1:0];
            end
        end
    end

    assign vld = |live;

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R3
    masked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & mask) == '0);
endmodule

// File: rtl/exc_router.sv
// Module: maps a granted source to its target mode and vector base select.
// Assumes: idx is valid only when the arbiter reports a grant.
module exc_router
    import exc_route_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [$clog2(N)-1:0] idx,
    input  logic [N-1:0]         route_mon,
    output exc_mode_e            mode,
    output logic                 to_mon
);
    // Purpose: choose monitor when the source's routing bit is set, else its default mode.
    always_comb begin
        to_mon = route_mon[idx];
        if (to_mon) begin
            mode = MD_MON;
        end else begin
            case (idx)
                2'(IDX_ABT): mode = MD_ABT;
                2'(IDX_FIQ): mode = MD_FIQ;
                default:     mode = MD_IRQ;
            endcase
        end
    end
endmodule

// File: rtl/exc_mask_filter.sv
// Module: holds the mask bits and applies the non-secure set protection per bit.
// Assumes: ns_i is the security state held before this edge's updates.
module exc_mask_filter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ns_i,
    input  logic         wr_en,
    input  logic [N-1:0] wr_val,
    input  logic [N-1:0] lock,
    output logic [N-1:0] mask_q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic blocked;
        assign blocked = wr_val[g] && ns_i && lock[g];

        // Purpose: update one mask bit unless a protected non-secure set is attempted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[g] <= 1'b0;
            else if (wr_en && !blocked)
                mask_q[g] <= wr_val[g];
        end

        // R8 R9
        locked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_val[g] && ns_i && lock[g] && !mask_q[g]) |=> !mask_q[g]);

        // R10
        free_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (!ns_i || !wr_val[g] || !lock[g])) |=> (mask_q[g] == $past(wr_val[g])));
    end
endmodule

// File: rtl/exc_route_ctrl.sv
// Module: top of the secure exception routing controller. Registers the grant,
// its target mode and base select, and owns the security-state bit.
// Assumes: requests are levels sampled each edge; one grant per cycle.
module exc_route_ctrl
    import exc_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_abt,
    input  logic       req_fiq,
    input  logic       req_irq,
    input  logic       dbg_mode,
    input  logic       route_abt_mon,
    input  logic       route_fiq_mon,
    input  logic       route_irq_mon,
    input  logic       lock_abt_mask,
    input  logic       lock_fiq_mask,
    input  logic       ns_wr,
    input  logic       ns_wr_val,
    input  logic       msk_wr,
    input  logic       msk_wr_a,
    input  logic       msk_wr_f,
    input  logic       msk_wr_i,
    output logic       ns_state,
    output logic       mask_a,
    output logic       mask_f,
    output logic       mask_i,
    output logic       take_vld,
    output logic [1:0] take_mode,
    output logic       take_mon_base
);
    localparam int IW = $clog2(NSRC);

    logic [NSRC-1:0] req_v, route_v, lock_v, wval_v, mask_v, gnt;
    logic [IW-1:0]   gidx;
    logic            gvld, to_mon, mon_entry;
    exc_mode_e       gmode;
    logic            ns_q;

    assign req_v   = {req_irq, req_fiq, req_abt};
    assign route_v = {route_irq_mon, route_fiq_mon, route_abt_mon};
    assign lock_v  = {1'b0, lock_fiq_mask, lock_abt_mask};
    assign wval_v  = {msk_wr_i, msk_wr_f, msk_wr_a};

    exc_arbiter #(.N(NSRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_v), .mask(mask_v),
        .vld(gvld), .gnt(gnt), .idx(gidx)
    );

    exc_router #(.N(NSRC)) u_rt (
        .idx(gidx), .route_mon(route_v), .mode(gmode), .to_mon(to_mon)
    );

    exc_mask_filter #(.N(NSRC)) u_msk (
        .clk(clk), .rst_n(rst_n), .ns_i(ns_q), .wr_en(msk_wr),
        .wr_val(wval_v), .lock(lock_v), .mask_q(mask_v)
    );

    assign mon_entry = gvld && to_mon;

    // Purpose: security-state bit; a non-debug monitor entry forces secure over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ns_q <= 1'b0;
        else if (mon_entry && !dbg_mode)
            ns_q <= 1'b0;
        else if (ns_wr)
            ns_q <= ns_wr_val;
    end

    // Purpose: register the grant with its target mode and vector base select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_vld      <= 1'b0;
            take_mode     <= 2'd0;
            take_mon_base <= 1'b0;
        end else begin
            take_vld      <= gvld;
            take_mode     <= gvld ? gmode : 2'd0;
            take_mon_base <= gvld && to_mon;
        end
    end

    assign ns_state = ns_q;
    assign mask_a   = mask_v[IDX_ABT];
    assign mask_f   = mask_v[IDX_FIQ];
    assign mask_i   = mask_v[IDX_IRQ];

    // R6
    mon_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_entry && !dbg_mode) |=> !ns_state);

    // R7
    dbg_keep_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_entry && dbg_mode && !ns_wr) |=> $stable(ns_state));

    // R5
    mon_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> (take_mon_base == (take_mode == 2'd3)));

    // R2
    grant_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_abt || req_fiq || req_irq) |=> !take_vld);
endmodule

// File: tb/exc_route_ctrl_bench.sv
module exc_route_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_abt = 0, req_fiq = 0, req_irq = 0, dbg_mode = 0;
    logic route_abt_mon = 0, route_fiq_mon = 0, route_irq_mon = 0;
    logic lock_abt_mask = 0, lock_fiq_mask = 0;
    logic ns_wr = 0, ns_wr_val = 0, msk_wr = 0, msk_wr_a = 0, msk_wr_f = 0, msk_wr_i = 0;
    logic ns_state, mask_a, mask_f, mask_i, take_vld, take_mon_base;
    logic [1:0] take_mode;

    int nvec = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    exc_route_ctrl u_exc_route_ctrl (.*);

    // Vector: {req abt,fiq,irq | route abt,fiq,irq | dbg | exp vld | exp mode[1:0] | exp mon | exp ns}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        12'b100_000_0_1_00_0_1, // R4 abort default
        12'b010_000_0_1_01_0_1, // R4 fiq default
        12'b001_000_0_1_10_0_1, // R4 irq default
        12'b111_000_0_1_00_0_1, // R2 abort first
        12'b011_000_0_1_01_0_1, // R2 fiq before irq
        12'b100_100_0_1_11_1_0, // R5 R6 abort to monitor
        12'b010_010_0_1_11_1_0, // R5 R6 fiq to monitor
        12'b001_001_1_1_11_1_1, // R7 debug keeps ns
        12'b011_001_0_1_01_0_1, // R2 R4 fiq wins, not routed
        12'b000_111_0_0_00_0_1, // R2 nothing pending
        12'b111_011_0_1_00_0_1, // R4 abort unrouted
        12'b001_001_0_1_11_1_0  // R5 R6 irq to monitor
    };

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ns(input logic v);
        ns_wr = 1; ns_wr_val = v; step(); ns_wr = 0;
    endtask

    task automatic wr_mask(input logic a, input logic f, input logic i);
        msk_wr = 1; msk_wr_a = a; msk_wr_f = f; msk_wr_i = i; step(); msk_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 ns", ns_state, 0);
        chk("R1 masks", {mask_a, mask_f, mask_i}, 0);
        chk("R1 vld", take_vld, 0);

        // table walk, ns=1 and masks clear before each vector
        for (int v = 0; v < NV; v++) begin
            set_ns(1'b1);
            wr_mask(0, 0, 0);
            {req_abt, req_fiq, req_irq} = VEC[v][11:9];
            {route_abt_mon, route_fiq_mon, route_irq_mon} = VEC[v][8:6];
            dbg_mode = VEC[v][5];
            step();
            req_abt = 0; req_fiq = 0; req_irq = 0;
            chk($sformatf("R2 vec%0d vld", v), take_vld, VEC[v][4]);
            chk($sformatf("R4 R5 vec%0d mode", v), take_mode, VEC[v][3:2]);
            chk($sformatf("R5 vec%0d base", v), take_mon_base, VEC[v][1]);
            chk($sformatf("R6 R7 vec%0d ns", v), ns_state, VEC[v][0]);
            route_abt_mon = 0; route_fiq_mon = 0; route_irq_mon = 0; dbg_mode = 0;
        end

        // R3 masks block: secure write sets a,f; all requests -> irq
        set_ns(1'b0);
        wr_mask(1, 1, 0);
        chk("R10 secure set", {mask_a, mask_f, mask_i}, 3'b110);
        req_abt = 1; req_fiq = 1; req_irq = 1; step();
        req_abt = 0; req_fiq = 0; req_irq = 0;
        chk("R3 skip masked", take_mode, 2);
        chk("R3 vld", take_vld, 1);
        wr_mask(1, 1, 1);
        req_abt = 1; req_fiq = 1; req_irq = 1; step();
        req_abt = 0; req_fiq = 0; req_irq = 0;
        chk("R3 all masked", take_vld, 0);

        // R8 R9 non-secure locked sets ignored, irq mask free
        wr_mask(0, 0, 0);
        set_ns(1'b1);
        lock_abt_mask = 1; lock_fiq_mask = 1;
        wr_mask(1, 1, 1);
        chk("R8 abort lock", mask_a, 0);
        chk("R9 fiq lock", mask_f, 0);
        chk("R10 irq free", mask_i, 1);
        lock_fiq_mask = 0;
        wr_mask(1, 1, 1);
        chk("R8 abort still locked", mask_a, 0);
        chk("R10 fiq unlocked", mask_f, 1);
        lock_fiq_mask = 1;
        wr_mask(0, 0, 0);
        chk("R10 clear under lock", {mask_f, mask_i}, 0);

        // R11 routed abort with locked non-secure mask set, same cycle
        route_abt_mon = 1;
        req_abt = 1; msk_wr = 1; msk_wr_a = 1; msk_wr_f = 0; msk_wr_i = 0;
        step();
        req_abt = 0; msk_wr = 0;
        chk("R11 mode", take_mode, 3);
        chk("R11 ns cleared", ns_state, 0);
        chk("R11 write judged non-secure", mask_a, 0);

        // R6 monitor entry beats ns write
        set_ns(1'b1);
        req_abt = 1; ns_wr = 1; ns_wr_val = 1;
        step();
        req_abt = 0; ns_wr = 0;
        chk("R6 entry over write", ns_state, 0);

        // R11 grant uses pre-write mask: secure set of a with abort pending
        route_abt_mon = 0;
        req_abt = 1; msk_wr = 1; msk_wr_a = 1;
        step();
        req_abt = 0; msk_wr = 0;
        chk("R11 grant old mask", take_mode, 0);
        chk("R11 mask written", mask_a, 1);

        // R1 reset mid-run
        rst_n = 0; step(); rst_n = 1;
        chk("R1 rerst", {ns_state, mask_a, mask_f, mask_i, take_vld}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule